// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block keeps one processor's private write-back cache coherent with its peers on a shared snooping bus, using four line states: Modified (dirty, only copy), Exclusive (clean, only copy), Shared (clean, copies may exist elsewhere) and Invalid. Writes invalidate other copies rather than updating them. It holds a small direct-mapped array of state, tag and one data word per line. The processor talks to it through a request/ready handshake. Bus access goes through a request/grant handshake with an arbiter that the controller does not model.

On a read miss the controller issues a bus read. In the grant cycle it samples the wired-OR shared response of the other caches and fills the line Shared or Exclusive. A write to an Exclusive line becomes Modified with no bus traffic. A write to a Shared or absent line first gains ownership with a read-exclusive request. In the other direction, every bus transaction is presented on the snoop port. A snooped read of a held line raises this cache's contribution to the shared line and may supply data. A snooped read-exclusive invalidates the line.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: the first processor access to any address goes to the bus, and no snoop sees a shared response.
- R2: A read miss issues a bus read (bus_cmd 2'b00) at the requested address. The processor receives bus_rdata with cpu_ready in the grant cycle. The line fills Shared if bus_shared_in is high in that grant cycle, and Exclusive otherwise.
- R3: A write to a line held Exclusive or Modified completes in its request cycle with no bus request, and the line becomes Modified.
- R4: A write to a Shared or absent line issues a read-exclusive (bus_cmd 2'b01), which stays stable until granted. It completes in the grant cycle and leaves the line Modified with the written data.
- R5: A snooped read (snp_cmd 0) whose address matches a line in Shared, Exclusive or Modified raises snp_shared in the same cycle. snp_shared stays low on a snoop miss and on any read-exclusive snoop.
- R6: A snooped read of a Modified line raises snp_flush with the line data on snp_data, and the line becomes Shared.
- R7: A snooped read-exclusive (snp_cmd 1) makes a held line Invalid. A Modified line flushes its data; Shared and Exclusive lines do not.
- R8: With cache-to-cache transfer enabled (parameter C2C=1), a snooped read of an Exclusive line supplies its data with snp_flush and the line becomes Shared. A Shared line never supplies data.
- R9: The set index is the low log2(SETS) address bits. A miss whose victim is Modified first issues a write-back (bus_cmd 2'b10) carrying the victim's address and data, then the fill. Shared and Exclusive victims are dropped with no bus traffic.
- R10: A read hit returns the stored word with cpu_ready in the request cycle and no bus request.
- R11: Snoops take priority: cpu_ready is low in every cycle where snp_valid is high, and a pending processor request is served after the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus transaction request, held until grant |
| bus_cmd | output | 2 | 00 read, 01 read-exclusive, 10 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Transaction takes place this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with grant |
| bus_shared_in | input | 1 | Wired-OR shared response of the other caches, valid with grant |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 1 | 0 read, 1 read-exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache's contribution to the shared line |
| snp_flush | output | 1 | This cache supplies snp_data |
| snp_data | output | DATA_W | Line data supplied on a flush |

## Verification
A wrong line state appears at the ports no later than the next access to that line. A line left Exclusive where Shared is correct lets a later write complete in its request cycle with no read-exclusive on the bus. A line wrongly Shared or Invalid makes a write or read reach the bus when it should not. A line kept valid after a read-exclusive snoop still raises snp_shared or snp_flush on the next snooped read. A lost write-back shows up as stale data when the evicted address is fetched again from the bench's memory model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } line_st_t;

   typedef enum logic [1:0] {
      BUS_RD  = 2'b00,
      BUS_RDX = 2'b01,
      BUS_WB  = 2'b10
   } bus_cmd_t;

   localparam logic SNP_RD  = 1'b0;
   localparam logic SNP_RDX = 1'b1;

   function automatic logic line_valid(input line_st_t st);
      return st != ST_I;
   endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
   import mesi_pkg::*;
#(
   parameter int SETS   = 4,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  cpu_idx,
   output line_st_t          cpu_st,
   output logic [TAG_W-1:0]  cpu_tag,
   output logic [DATA_W-1:0] cpu_data,
   input  logic [IDX_W-1:0]  snp_idx,
   output line_st_t          snp_st,
   output logic [TAG_W-1:0]  snp_tag,
   output logic [DATA_W-1:0] snp_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_st_t          wr_st,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sw_en,
   input  logic [IDX_W-1:0]  sw_idx,
   input  line_st_t          sw_st
);

   line_st_t          st_all   [SETS];
   logic [TAG_W-1:0]  tag_all  [SETS];
   logic [DATA_W-1:0] data_all [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] data_r;
      logic              own_wr;
      logic              own_sw;

      assign own_wr = wr_en && (wr_idx == IDX_W'(s));
      assign own_sw = sw_en && (sw_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r   <= ST_I;
            tag_r  <= '0;
            data_r <= '0;
         end else begin
            // snoop update wins on a same-line collision
            if (own_sw)      st_r <= sw_st;
            else if (own_wr) st_r <= wr_st;
            if (own_wr) begin
               tag_r  <= wr_tag;
               data_r <= wr_data;
            end
         end
      end

      assign st_all[s]   = st_r;
      assign tag_all[s]  = tag_r;
      assign data_all[s] = data_r;
   end

   assign cpu_st   = st_all[cpu_idx];
   assign cpu_tag  = tag_all[cpu_idx];
   assign cpu_data = data_all[cpu_idx];
   assign snp_st   = st_all[snp_idx];
   assign snp_tag  = tag_all[snp_idx];
   assign snp_data = data_all[snp_idx];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter bit C2C   = 1'b1
) (
   input  logic             snp_valid,
   input  logic             snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_t         line_st,
   input  logic [TAG_W-1:0] line_tag,
   output logic             shared,
   output logic             flush,
   output logic             upd_en,
   output line_st_t         upd_st
);

   logic held;
   logic e_supplies;

   if (C2C) begin : g_c2c
      assign e_supplies = 1'b1;
   end else begin : g_mem_only
      assign e_supplies = 1'b0;
   end

   assign held = snp_valid && line_valid(line_st) && (line_tag == snp_tag);

   always_comb begin
      shared = 1'b0;
      flush  = 1'b0;
      upd_en = 1'b0;
      upd_st = line_st;
      if (held) begin
         if (snp_cmd == SNP_RD) begin
            shared = 1'b1;
            flush  = (line_st == ST_M) || ((line_st == ST_E) && e_supplies);
            upd_en = (line_st == ST_M) || (line_st == ST_E);
            upd_st = ST_S;
         end else begin
            flush  = (line_st == ST_M);
            upd_en = 1'b1;
            upd_st = ST_I;
         end
      end
   end

endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
   import mesi_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [IDX_W-1:0]        cpu_idx,
   input  logic [TAG_W-1:0]        cpu_tag,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic                    cpu_ready,
   output logic [DATA_W-1:0]       cpu_rdata,
   input  line_st_t                line_st,
   input  logic [TAG_W-1:0]        line_tag,
   input  logic [DATA_W-1:0]       line_data,
   input  logic                    snp_busy,
   output logic                    bus_req,
   output bus_cmd_t                bus_cmd,
   output logic [TAG_W+IDX_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]       bus_wdata,
   input  logic                    bus_gnt,
   input  logic                    bus_shared,
   input  logic [DATA_W-1:0]       bus_rdata,
   output logic                    wr_en,
   output line_st_t                wr_st,
   output logic [TAG_W-1:0]        wr_tag,
   output logic [DATA_W-1:0]       wr_data
);

   typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL} fsm_t;

   fsm_t     st_q, st_d;
   bus_cmd_t fill_q, fill_d;
   logic     hit;

   assign hit = line_valid(line_st) && (line_tag == cpu_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= F_IDLE;
         fill_q <= BUS_RD;
      end else begin
         st_q   <= st_d;
         fill_q <= fill_d;
      end
   end

   always_comb begin
      st_d      = st_q;
      fill_d    = fill_q;
      cpu_ready = 1'b0;
      cpu_rdata = line_data;
      bus_req   = 1'b0;
      bus_cmd   = fill_q;
      bus_addr  = {cpu_tag, cpu_idx};
      bus_wdata = line_data;
      wr_en     = 1'b0;
      wr_st     = ST_M;
      wr_tag    = cpu_tag;
      wr_data   = cpu_wdata;
      unique case (st_q)
         F_IDLE: begin
            if (cpu_req && !snp_busy) begin
               if (hit && !cpu_we) begin
                  cpu_ready = 1'b1;
               end else if (hit && (line_st == ST_M || line_st == ST_E)) begin
                  cpu_ready = 1'b1;
                  wr_en     = 1'b1;
               end else begin
                  fill_d = cpu_we ? BUS_RDX : BUS_RD;
                  st_d   = (!hit && line_st == ST_M) ? F_WB : F_FILL;
               end
            end
         end
         F_WB: begin
            bus_cmd  = BUS_WB;
            bus_addr = {line_tag, cpu_idx};
            if (line_st != ST_M) begin
               st_d = F_FILL;      // victim lost ownership to a snoop
            end else begin
               bus_req = 1'b1;
               if (bus_gnt) begin
                  wr_en   = 1'b1;
                  wr_st   = ST_E;   // memory now current, copy still sole
                  wr_tag  = line_tag;
                  wr_data = line_data;
                  st_d    = F_FILL;
               end
            end
         end
         F_FILL: begin
            bus_req = 1'b1;
            if (bus_gnt) begin
               cpu_ready = 1'b1;
               cpu_rdata = bus_rdata;
               wr_en     = 1'b1;
               wr_st     = cpu_we ? ST_M : (bus_shared ? ST_S : ST_E);
               wr_data   = cpu_we ? cpu_wdata : bus_rdata;
               st_d      = F_IDLE;
            end
         end
         default: st_d = F_IDLE;
      endcase
   end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int SETS   = 4,
   parameter bit C2C    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic              snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_data
);

   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W;

   initial begin
      assert (SETS >= 2 && (1 << IDX_W) == SETS)
         else $error("SETS must be a power of two of at least 2");
      assert (TAG_W >= 1) else $error("ADDR_W too small for SETS");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  c_idx, s_idx;
   logic [TAG_W-1:0]  c_tag, s_tag;
   line_st_t          c_line_st, s_line_st, wr_st, sw_st;
   logic [TAG_W-1:0]  c_line_tag, s_line_tag, wr_tag;
   logic [DATA_W-1:0] c_line_data, wr_data;
   logic              wr_en, sw_en;
   bus_cmd_t          cmd_e;

   assign c_idx = cpu_addr[IDX_W-1:0];
   assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tag = snp_addr[ADDR_W-1:IDX_W];

   mesi_line_array #(
      .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_idx  (c_idx),
      .cpu_st   (c_line_st),
      .cpu_tag  (c_line_tag),
      .cpu_data (c_line_data),
      .snp_idx  (s_idx),
      .snp_st   (s_line_st),
      .snp_tag  (s_line_tag),
      .snp_data (snp_data),
      .wr_en    (wr_en),
      .wr_idx   (c_idx),
      .wr_st    (wr_st),
      .wr_tag   (wr_tag),
      .wr_data  (wr_data),
      .sw_en    (sw_en),
      .sw_idx   (s_idx),
      .sw_st    (sw_st)
   );

   mesi_snoop_resp #(.TAG_W(TAG_W), .C2C(C2C)) u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (snp_cmd),
      .snp_tag   (s_tag),
      .line_st   (s_line_st),
      .line_tag  (s_line_tag),
      .shared    (snp_shared),
      .flush     (snp_flush),
      .upd_en    (sw_en),
      .upd_st    (sw_st)
   );

   mesi_cpu_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_idx    (c_idx),
      .cpu_tag    (c_tag),
      .cpu_wdata  (cpu_wdata),
      .cpu_ready  (cpu_ready),
      .cpu_rdata  (cpu_rdata),
      .line_st    (c_line_st),
      .line_tag   (c_line_tag),
      .line_data  (c_line_data),
      .snp_busy   (snp_valid),
      .bus_req    (bus_req),
      .bus_cmd    (cmd_e),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_gnt    (bus_gnt),
      .bus_shared (bus_shared_in),
      .bus_rdata  (bus_rdata),
      .wr_en      (wr_en),
      .wr_st      (wr_st),
      .wr_tag     (wr_tag),
      .wr_data    (wr_data)
   );

   assign bus_cmd = cmd_e;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              bus_req,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_gnt,
   input logic              snp_valid,
   input logic              snp_cmd,
   input logic              snp_shared,
   input logic              snp_flush
);

   // R11: a snoop cycle never completes a processor request
   a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ready);

   // R3, R10: completion without a grant means no bus traffic
   a_r3_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !bus_gnt) |-> !bus_req);

   // R4: a pending request holds command and address until granted
   a_r4_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && !snp_valid) |=>
         (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

   // R9: the write-back beat never completes the processor request
   a_r9_wb_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'b10) |-> !cpu_ready);

   // R5, R7: shared response only for snooped reads
   a_r5_shared_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> (snp_valid && snp_cmd == 1'b0));

   // R6: data is only supplied during a snoop
   a_r6_flush_in_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_valid);

   // R2: the bus is used only on behalf of a processor request
   a_r2_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> cpu_req);

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_ready  (cpu_ready),
   .bus_req    (bus_req),
   .bus_cmd    (bus_cmd),
   .bus_addr   (bus_addr),
   .bus_gnt    (bus_gnt),
   .snp_valid  (snp_valid),
   .snp_cmd    (snp_cmd),
   .snp_shared (snp_shared),
   .snp_flush  (snp_flush)
);

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb;

   localparam logic [1:0] C_RD  = 2'b00;
   localparam logic [1:0] C_RDX = 2'b01;
   localparam logic [1:0] C_WB  = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [15:0] cpu_rdata;
   logic        bus_req;
   logic [1:0]  bus_cmd;
   logic [7:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic        bus_gnt = 1'b0;
   logic [15:0] bus_rdata = '0;
   logic        bus_shared_in = 1'b0;
   logic        snp_valid = 1'b0, snp_cmd = 1'b0;
   logic [7:0]  snp_addr = '0;
   logic        snp_shared, snp_flush;
   logic [15:0] snp_data;

   always #2.5 clk = ~clk;

   mesi_snoop_ctrl #(.ADDR_W(8), .DATA_W(16), .SETS(4), .C2C(1'b1)) u_dut (.*);

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   logic [15:0] mem [256];

   logic [1:0]  t_cmd   [4];
   logic [7:0]  t_addr  [4];
   logic [15:0] t_wdata [4];
   int          t_n;
   logic [15:0] t_rd;
   bit          t_done;

   function automatic logic [15:0] init_val(input int a);
      return 16'h0100 + 16'(a * 3);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cpu_op(input logic we, input logic [7:0] a,
                         input logic [15:0] wd, input logic shr);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      t_n = 0; t_done = 0; t_rd = 'x;
      for (int cyc = 0; cyc < 20 && !t_done; cyc++) begin
         #1;
         if (bus_req && t_n < 4) begin
            t_cmd[t_n] = bus_cmd; t_addr[t_n] = bus_addr; t_wdata[t_n] = bus_wdata;
            t_n++;
            bus_gnt = 1'b1; bus_rdata = mem[bus_addr]; bus_shared_in = shr;
            if (bus_cmd == C_WB) mem[bus_addr] = bus_wdata;
            #0.5;
         end
         if (cpu_ready) begin t_rd = cpu_rdata; t_done = 1; end
         @(posedge clk);
         @(negedge clk);
         bus_gnt = 1'b0; bus_shared_in = 1'b0;
      end
      cpu_req = 1'b0;
      chk("R11", "request completed", 32'(t_done), 32'd1);
   endtask

   task automatic snoop(input logic cmd, input logic [7:0] a, input string req,
                        input logic exp_sh, input logic exp_fl,
                        input bit chk_data, input logic [15:0] exp_d);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
      #1;
      chk(req, "snp_shared", 32'(snp_shared), 32'(exp_sh));
      chk(req, "snp_flush", 32'(snp_flush), 32'(exp_fl));
      if (chk_data) chk(req, "snp_data", 32'(snp_data), 32'(exp_d));
      @(posedge clk);
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   typedef struct packed {
      logic        we;
      logic [7:0]  addr;
      logic [15:0] wdata;
      logic        shr;
      logic [2:0]  nbus;
      logic [1:0]  cmd0;
      logic [1:0]  cmd_last;
      logic        is_rd;
      logic [15:0] rdata;
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{1'b0, 8'h10, 16'h0000, 1'b0, 3'd1, C_RD,  C_RD,  1'b1, 16'h0130}, // R1 R2 miss, fills E
      '{1'b1, 8'h10, 16'hAAAA, 1'b0, 3'd0, C_RD,  C_RD,  1'b0, 16'h0000}, // R3 silent E->M
      '{1'b0, 8'h10, 16'h0000, 1'b0, 3'd0, C_RD,  C_RD,  1'b1, 16'hAAAA}, // R10 hit
      '{1'b0, 8'h21, 16'h0000, 1'b1, 3'd1, C_RD,  C_RD,  1'b1, 16'h0163}, // R2 fills S
      '{1'b1, 8'h21, 16'hBBBB, 1'b0, 3'd1, C_RDX, C_RDX, 1'b0, 16'h0000}, // R4 upgrade S
      '{1'b1, 8'h32, 16'hCCCC, 1'b0, 3'd1, C_RDX, C_RDX, 1'b0, 16'h0000}, // R4 write miss
      '{1'b0, 8'h30, 16'h0000, 1'b0, 3'd2, C_WB,  C_RD,  1'b1, 16'h0190}, // R9 M victim
      '{1'b0, 8'h10, 16'h0000, 1'b1, 3'd1, C_RD,  C_RD,  1'b1, 16'hAAAA}, // R9 E victim silent
      '{1'b1, 8'h10, 16'h1111, 1'b0, 3'd1, C_RDX, C_RDX, 1'b0, 16'h0000}  // R2 shared fill -> RDX
   };

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R1 reset state
      chk("R1", "bus_req after reset", 32'(bus_req), 32'd0);
      chk("R1", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++)
         snoop(1'b0, 8'(a * 16 + a), "R1", 1'b0, 1'b0, 1'b0, 16'h0);

      // table walk
      for (int v = 0; v < 9; v++) begin
         cpu_op(VEC[v].we, VEC[v].addr, VEC[v].wdata, VEC[v].shr);
         chk("R2/R3/R4/R9/R10", $sformatf("vec %0d bus count", v), 32'(t_n), 32'(VEC[v].nbus));
         if (VEC[v].nbus != 0 && t_n != 0) begin
            chk("R9", $sformatf("vec %0d first cmd", v), 32'(t_cmd[0]), 32'(VEC[v].cmd0));
            chk("R2", $sformatf("vec %0d fill cmd", v), 32'(t_cmd[t_n-1]), 32'(VEC[v].cmd_last));
            chk("R2", $sformatf("vec %0d fill addr", v), 32'(t_addr[t_n-1]), 32'(VEC[v].addr));
         end
         if (VEC[v].is_rd)
            chk("R10", $sformatf("vec %0d rdata", v), 32'(t_rd), 32'(VEC[v].rdata));
         if (v == 6) begin
            chk("R9", "write-back addr", 32'(t_addr[0]), 32'h10);
            chk("R9", "write-back data", 32'(t_wdata[0]), 32'hAAAA);
         end
      end

      // R6: snooped read of Modified line 0x10 flushes, demotes to S
      snoop(1'b0, 8'h10, "R6", 1'b1, 1'b1, 1'b1, 16'h1111);
      cpu_op(1'b1, 8'h10, 16'h2222, 1'b0);
      chk("R6", "write after demote bus count", 32'(t_n), 32'd1);
      chk("R6", "write after demote cmd", 32'(t_cmd[0]), 32'(C_RDX));

      // R5: same index, other tag -> miss
      snoop(1'b0, 8'h14, "R5", 1'b0, 1'b0, 1'b0, 16'h0);

      // R7: read-exclusive snoop on Modified 0x21
      snoop(1'b1, 8'h21, "R7", 1'b0, 1'b1, 1'b1, 16'hBBBB);
      cpu_op(1'b0, 8'h21, 16'h0, 1'b0);
      chk("R7", "read after M invalidation goes to bus", 32'(t_n), 32'd1);
      chk("R2", "refill data", 32'(t_rd), 32'h0163);

      // R8: E supplies data, then S does not
      snoop(1'b0, 8'h21, "R8", 1'b1, 1'b1, 1'b1, 16'h0163);
      snoop(1'b0, 8'h21, "R8", 1'b1, 1'b0, 1'b0, 16'h0);

      // R7: S invalidates without flush
      snoop(1'b1, 8'h21, "R7", 1'b0, 1'b0, 1'b0, 16'h0);
      cpu_op(1'b0, 8'h21, 16'h0, 1'b0);
      chk("R7", "read after S invalidation goes to bus", 32'(t_n), 32'd1);
      // R7: E invalidates without flush
      snoop(1'b1, 8'h21, "R7", 1'b0, 1'b0, 1'b0, 16'h0);
      cpu_op(1'b0, 8'h21, 16'h0, 1'b0);
      chk("R7", "read after E invalidation goes to bus", 32'(t_n), 32'd1);

      // R11: snoop blocks a pending hit for one cycle
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h32;
      snp_valid = 1'b1; snp_cmd = 1'b0; snp_addr = 8'h03;
      #1;
      chk("R11", "ready during snoop", 32'(cpu_ready), 32'd0);
      chk("R5", "shared on absent line", 32'(snp_shared), 32'd0);
      @(posedge clk);
      @(negedge clk);
      snp_valid = 1'b0;
      #1;
      chk("R11", "ready after snoop", 32'(cpu_ready), 32'd1);
      chk("R11", "rdata after snoop", 32'(cpu_rdata), 32'hCCCC);
      chk("R10", "no bus on hit", 32'(bus_req), 32'd0);
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule